// File: doc/BRIEF.md
# Bus-Invert Data Codec

This block reduces switching activity on a wide parallel data link. One extra flag wire travels with the data lines. For every accepted word, the transmit side compares the word with the pattern it is already driving. It counts how many wires would change if the word went out as it is, and how many would change if its complement went out instead. The flag wire is included in both counts. The cheaper form is driven, and the flag tells the receiver which form it sees. When both forms cost the same, the flag keeps its present value.

The receive side flips every data line when the flag is high and returns the original word with a valid strobe. The transmit register holds the driven pattern, and that pattern is the reference for the next word. Idle cycles leave the link untouched. Values are plain two's complement words. The width is a parameter with a default of 32.

Top module: `bus_invert_codec`

## Requirements
- R1: On the clock edge that accepts a word (in_valid high), link_data becomes in_data when link_flag is 0, or the bitwise complement of in_data when link_flag is 1.
- R2: Let P be the number of link wires, data and flag together, that would toggle if the word were sent unchanged. Let Q be the number that would toggle if it were sent complemented. When Q < P the complemented form is driven (flag 1). When P < Q the word is driven unchanged (flag 0).
- R3: When P equals Q, link_flag keeps its previous value. This tie can only occur when WIDTH is odd.
- R4: On one accepted word, at most floor((WIDTH+1)/2) of the WIDTH+1 link wires toggle.
- R5: While in_valid is low, link_data and link_flag hold their values and no decoded word is produced.
- R6: Two clock edges after a word is accepted, out_valid is 1 and out_data equals that word. out_data is link_data with every bit flipped when link_flag was 1.
- R7: While rst_n is low, link_data, link_flag, out_valid and out_data are all 0.
- R8: From the reset state, sending 0 and then all ones leaves link_data at all zeros with link_flag 1 for the second word, so only the flag wire toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_data for this cycle |
| in_data | input | WIDTH | Word to transmit |
| link_data | output | WIDTH | Registered data wires of the link |
| link_flag | output | 1 | Registered inversion flag wire |
| out_valid | output | 1 | Decoded word valid |
| out_data | output | WIDTH | Decoded word |

## Verification
The bench builds two copies of the block. The first uses the default width of 32. With that width the total wire count is odd, so every decision is strict. This copy runs a hand-worked vector table, the zero-then-all-ones case, and a long pseudo-random stream checked against a model. The second copy uses a width of 3, where the wire count is even. This makes equal-cost choices reachable, so the tie rule can be shown keeping the flag at 0 and also keeping it at 1.

// File: rtl/bic_pkg.sv
package bic_pkg;

    // Outcome of the per-word comparison between the two candidate forms.
    typedef enum logic [1:0] {
        BIC_SEND_PLAIN    = 2'd0,
        BIC_SEND_INVERTED = 2'd1,
        BIC_KEEP_FLAG     = 2'd2
    } bic_choice_e;

    // Width of a counter able to hold the values 0 .. w+1.
    function automatic int bic_count_bits(input int w);
        return $clog2(w + 2);
    endfunction

endpackage

// File: rtl/bic_popcount.sv
module bic_popcount #(
    parameter int WIDTH = 32,
    parameter int CW    = 6
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CW-1:0]    cnt
);

    logic [CW-1:0] lane [WIDTH];

    // Widen each bit to the counter width.
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign lane[i] = {{(CW-1){1'b0}}, vec[i]};
    end

    always_comb begin
        cnt = '0;
        for (int i = 0; i < WIDTH; i++) begin
            cnt = cnt + lane[i];
        end
    end

endmodule

// File: rtl/bic_encoder.sv
module bic_encoder
    import bic_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int CW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic [WIDTH-1:0] enc_data,
    output logic             enc_flag,
    output logic             enc_valid
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             flag;
        logic             valid;
    } enc_state_t;

    enc_state_t    st_d, st_q;
    logic [CW-1:0] diff_cnt;
    logic [CW-1:0] cost_plain;
    logic [CW-1:0] cost_inv;
    bic_choice_e   choice;

    // Count the data wires that differ from the driven pattern.
    bic_popcount #(
        .WIDTH (WIDTH),
        .CW    (CW)
    ) u_diff (
        .vec (in_data ^ st_q.data),
        .cnt (diff_cnt)
    );

    always_comb begin
        // The flag wire toggles if the new form differs from the current flag.
        cost_plain = diff_cnt + {{(CW-1){1'b0}}, st_q.flag};
        cost_inv   = CW'(WIDTH) - diff_cnt + {{(CW-1){1'b0}}, ~st_q.flag};

        if (cost_inv < cost_plain) begin
            choice = BIC_SEND_INVERTED;
        end else if (cost_plain < cost_inv) begin
            choice = BIC_SEND_PLAIN;
        end else begin
            choice = BIC_KEEP_FLAG;
        end

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            case (choice)
                BIC_SEND_INVERTED: st_d.flag = 1'b1;
                BIC_SEND_PLAIN:    st_d.flag = 1'b0;
                default:           st_d.flag = st_q.flag;
            endcase
            st_d.data = in_data ^ {WIDTH{st_d.flag}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enc_data  = st_q.data;
    assign enc_flag  = st_q.flag;
    assign enc_valid = st_q.valid;

endmodule

// File: rtl/bic_decoder.sv
module bic_decoder #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_valid,
    input  logic [WIDTH-1:0] link_data,
    input  logic             link_flag,
    output logic             dec_valid,
    output logic [WIDTH-1:0] dec_data
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             valid;
    } dec_state_t;

    dec_state_t       st_d, st_q;
    logic [WIDTH-1:0] restored;

    // Each lane is flipped by the shared flag wire.
    for (genvar i = 0; i < WIDTH; i++) begin : g_restore
        assign restored[i] = link_data[i] ^ link_flag;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = link_valid;
        if (link_valid) begin
            st_d.data = restored;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid = st_q.valid;
    assign dec_data  = st_q.data;

endmodule

// File: rtl/bus_invert_codec.sv
module bus_invert_codec #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic [WIDTH-1:0] link_data,
    output logic             link_flag,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);

    localparam int CW = bic_pkg::bic_count_bits(WIDTH);

    logic link_valid;

    bic_encoder #(
        .WIDTH (WIDTH),
        .CW    (CW)
    ) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .enc_data  (link_data),
        .enc_flag  (link_flag),
        .enc_valid (link_valid)
    );

    bic_decoder #(
        .WIDTH (WIDTH)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_valid (link_valid),
        .link_data  (link_data),
        .link_flag  (link_flag),
        .dec_valid  (out_valid),
        .dec_data   (out_data)
    );

endmodule

// File: rtl/bic_checker.sv
module bic_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_data,
    input logic [WIDTH-1:0] link_data,
    input logic             link_flag,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_data
);

    localparam int HALF = (WIDTH + 1) / 2;

    // R1: the driven pattern is the word or its complement, as the flag says.
    assert_link_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (link_data == ($past(in_data) ^ {WIDTH{link_flag}})));

    // R4: the toggle count per accepted word is bounded.
    assert_toggle_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones({link_data, link_flag} ^
                                 {$past(link_data), $past(link_flag)}) <= HALF));

    // R5: idle cycles leave the link unchanged.
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(link_data) && $stable(link_flag)));

    // R6: the decoded word equals the accepted word two edges later.
    assert_roundtrip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_valid && (out_data == $past(in_data, 2))));

    // R5: no decoded word without an accepted word.
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R7: reset clears every output.
    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |-> (link_data == '0 && !link_flag && !out_valid && out_data == '0));

endmodule

bind bus_invert_codec bic_checker #(.WIDTH(WIDTH)) u_bic_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .link_data (link_data),
    .link_flag (link_flag),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_bus_invert_codec.sv
module tb_bus_invert_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [31:0] link_data;
    logic        link_flag;
    logic        out_valid;
    logic [31:0] out_data;

    logic        s_valid = 1'b0;
    logic [2:0]  s_data = '0;
    logic [2:0]  s_link;
    logic        s_flag;
    logic        s_ovalid;
    logic [2:0]  s_odata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_bus = '0;
    logic        m_flag = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    bus_invert_codec #(.WIDTH(32)) dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .link_data (link_data), .link_flag (link_flag),
        .out_valid (out_valid), .out_data (out_data)
    );

    bus_invert_codec #(.WIDTH(3)) dut_w3 (
        .clk (clk), .rst_n (rst_n), .in_valid (s_valid), .in_data (s_data),
        .link_data (s_link), .link_flag (s_flag),
        .out_valid (s_ovalid), .out_data (s_odata)
    );

    // {word, expected link_data, expected link_flag}, worked out from reset
    localparam logic [64:0] VEC [9] = '{
        {32'h0000_0000, 32'h0000_0000, 1'b0},
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        {32'h0000_FFFF, 32'hFFFF_0000, 1'b1},
        {32'h0000_FFFF, 32'hFFFF_0000, 1'b1},
        {32'h0000_0001, 32'hFFFF_FFFE, 1'b1},
        {32'h0000_0000, 32'hFFFF_FFFF, 1'b1},
        {32'h0000_0003, 32'hFFFF_FFFC, 1'b1},
        {32'hFFFF_FFFC, 32'hFFFF_FFFC, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference choice from the toggle-cost rule (R2, R3).
    task automatic model_step(input logic [31:0] w);
        int hd, cp, ci;
        hd = $countones(w ^ m_bus);
        cp = hd + int'(m_flag);
        ci = 32 - hd + int'(!m_flag);
        if (ci < cp)      m_flag = 1'b1;
        else if (cp < ci) m_flag = 1'b0;
        m_bus = w ^ {32{m_flag}};
    endtask

    task automatic send32(input logic [31:0] w);
        logic [31:0] pb;
        logic        pf;
        pb = link_data;
        pf = link_flag;
        model_step(w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
        check(link_flag == m_flag, "R2 flag choice", 64'(link_flag), 64'(m_flag));
        check(link_data == (w ^ {32{link_flag}}), "R1 link form", 64'(link_data),
              64'(w ^ {32{link_flag}}));
        check($countones({link_data, link_flag} ^ {pb, pf}) <= 16, "R4 toggle bound",
              64'($countones({link_data, link_flag} ^ {pb, pf})), 64'd16);
        @(negedge clk);
        check(out_valid && out_data == w, "R6 decoded word", 64'(out_data), 64'(w));
    endtask

    task automatic send3(input logic [2:0] w, input logic [2:0] eb, input logic ef,
                         input string req);
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = w;
        @(negedge clk);
        s_valid = 1'b0;
        check(s_flag == ef && s_link == eb, req, 64'({s_link, s_flag}), 64'({eb, ef}));
        @(negedge clk);
        check(s_ovalid && s_odata == w, "R6 decoded word width 3", 64'(s_odata), 64'(w));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(link_data == '0 && !link_flag, "R7 link cleared",
              64'({link_data, link_flag}), 64'd0);
        check(!out_valid && out_data == '0, "R7 decoded side cleared",
              64'({out_valid, out_data}), 64'd0);
        check(s_link == '0 && !s_flag && !s_ovalid, "R7 width 3 cleared",
              64'({s_link, s_flag, s_ovalid}), 64'd0);
        rst_n  = 1'b1;
        m_bus  = '0;
        m_flag = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();

        // Table walk: hand-derived link values from reset.
        for (int i = 0; i < 9; i++) begin
            send32(VEC[i][64:33]);
            check(link_data == VEC[i][32:1] && link_flag == VEC[i][0],
                  "R2 table vector", 64'({link_data, link_flag}), 64'(VEC[i][32:0]));
        end

        // Zero then all ones from reset: only the flag wire moves.
        do_reset();
        send32(32'h0000_0000);
        send32(32'hFFFF_FFFF);
        check(link_data == 32'h0 && link_flag, "R8 zero then all ones",
              64'({link_data, link_flag}), 64'd1);

        // Idle cycles with changing data leave the link alone.
        begin
            logic [31:0] hb;
            logic        hf;
            hb = link_data;
            hf = link_flag;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                in_data = 32'hA5A5_0000 + 32'(k);
                check(link_data == hb && link_flag == hf, "R5 idle hold",
                      64'({link_data, link_flag}), 64'({hb, hf}));
                check(!out_valid, "R5 no decoded word when idle", 64'(out_valid), 64'd0);
            end
        end

        // Back-to-back burst: decoded words arrive two edges after acceptance.
        begin
            logic [31:0] bw [4];
            bw[0] = 32'h0F0F_0F0F; bw[1] = 32'hF0F0_F0F0;
            bw[2] = 32'h0000_0001; bw[3] = 32'h7FFF_FFFF;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (k >= 2) begin
                    check(out_valid && out_data == bw[k-2], "R6 burst decode",
                          64'(out_data), 64'(bw[k-2]));
                end
                if (k < 4) begin
                    model_step(bw[k]);
                    in_valid = 1'b1;
                    in_data  = bw[k];
                end else begin
                    in_valid = 1'b0;
                end
            end
            check(link_data == m_bus && link_flag == m_flag, "R2 burst final state",
                  64'({link_data, link_flag}), 64'({m_bus, m_flag}));
        end

        // Pseudo-random stream, biased toward near-complement words.
        for (int n = 0; n < 300; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            if (n % 3 == 0) send32(~link_data ^ {16'h0, lfsr[15:0] & lfsr[31:16]});
            else            send32(lfsr);
        end

        // Width 3: equal costs keep the flag, both at 0 and at 1.
        do_reset();
        send3(3'b011, 3'b011, 1'b0, "R3 tie keeps flag at 0");
        send3(3'b100, 3'b011, 1'b1, "R2 width 3 inverts");
        send3(3'b111, 3'b000, 1'b1, "R3 tie keeps flag at 1");

        finish_run();
    end

endmodule